// File: doc/BRIEF.md
# Dual Window Voltage Supervisor

This block is the digital half of a two-channel window supervisor. Each channel (a "pair") watches one supply through two comparator bits that arrive already synchronized to the clock. The low-limit bit is high while the supply sits above its lower trip point. The high-limit bit is high while the supply sits above its upper trip point. From these bits the pair builds a low-side status, a high-side status and a power-good flag. All three are active-high logic levels.

Each status flag is qualified in time. A satisfied condition must hold for a long stability interval before its flag goes high. A violated condition must persist for a short filter interval before its flag drops. Shorter excursions are ignored. The two flags of a pair start differently. The high-side flag is asserted as soon as monitoring starts, while the low-side flag waits for qualification. Power-good is the conjunction of the two filtered flags.

A global bias-valid input and one enable per pair gate the monitoring. The two pairs share only the clock, reset and bias input, and they never influence each other. Both intervals are cycle-count parameters.

Top module: `dual_window_supervisor`

## Requirements
- R1: While reset is asserted, and from the first clock edge that samples `biasOk` low, every status and power-good output of both pairs is 0.
- R2: On the first edge that samples `biasOk`=1 and `en[p]`=1 after either was low, `ovStatus[p]` becomes 1 and `uvStatus[p]` and `pwrGood[p]` stay 0, whatever the comparator bits are.
- R3: `uvStatus[p]` rises only after `uvAbove[p]`=1 has been sampled on QUAL_CYCLES consecutive edges. Counting starts on the edge after monitoring starts, and a single sample of 0 restarts the count.
- R4: `pwrGood[p]` is 1 exactly when the filtered `uvStatus[p]` and `ovStatus[p]` are both 1. A raw comparator bit never drives it directly.
- R5: `uvStatus[p]` and `pwrGood[p]` drop after `uvAbove[p]`=0 has been sampled on FILT_CYCLES consecutive edges. Shorter low runs leave both outputs unchanged.
- R6: `ovStatus[p]` and `pwrGood[p]` drop after `ovAbove[p]`=1 has been sampled on FILT_CYCLES consecutive edges. Shorter high runs leave both outputs unchanged.
- R7: After a high-side fault, `ovStatus[p]` returns to 1 only after `ovAbove[p]`=0 has been sampled on QUAL_CYCLES consecutive edges.
- R8: From the first edge that samples `en[p]`=0, all three outputs of pair p are 0. When `en[p]` returns to 1, the pair restarts as in R2 and R3.
- R9: Inputs and enable of one pair never change the outputs of the other pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| biasOk | input | 1 | Supply bias valid; low forces all outputs low |
| en | input | NUM_PAIRS | Per-pair monitoring enable |
| uvAbove | input | NUM_PAIRS | Synchronized comparator: supply above lower limit |
| ovAbove | input | NUM_PAIRS | Synchronized comparator: supply above upper limit |
| uvStatus | output | NUM_PAIRS | Qualified low-side status, 1 = lower limit met |
| ovStatus | output | NUM_PAIRS | Qualified high-side status, 1 = below upper limit |
| pwrGood | output | NUM_PAIRS | Per-pair power-good, 1 = supply inside window |

## Verification
The assertions assume that the comparator bits, the enables and the bias input are already synchronous to the clock. They also assume that each of these inputs holds a value for whole cycles. The bench meets this by changing every input only on the falling edge, so that each rising edge samples a settled value. The properties also assume a correct reset: every comparison with a past value is made against cycles in which reset or the gating inputs had already defined the flags. The bench shortens both intervals to a few cycles. This lets glitches one cycle shorter than the filter, runs that are interrupted before qualification, and runs that reach exactly the limit all be exercised on both pairs.

// File: rtl/dws_pkg.sv
package dws_pkg;

  // State of one qualified flag
  typedef enum logic [1:0] {
    FL_OFF  = 2'd0,
    FL_LOW  = 2'd1,
    FL_HIGH = 2'd2
  } flagState_t;

  // Strobes from control to one datapath counter
  typedef struct packed {
    logic clr;
    logic inc;
  } cntCmd_t;

endpackage

// File: rtl/dws_datapath.sv
module dws_datapath
  import dws_pkg::*;
#(
  parameter int NUM_FLAGS   = 4,
  parameter int QUAL_CYCLES = 20_000_000,
  parameter int FILT_CYCLES = 3750
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  cntCmd_t [NUM_FLAGS-1:0]        cmd,
  output logic    [NUM_FLAGS-1:0]        hitQual,
  output logic    [NUM_FLAGS-1:0]        hitFilt
);

  localparam int MAX_LIM = (QUAL_CYCLES > FILT_CYCLES) ? QUAL_CYCLES : FILT_CYCLES;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);
  localparam logic [CNT_W-1:0] QUAL_LAST = CNT_W'(QUAL_CYCLES - 1);
  localparam logic [CNT_W-1:0] FILT_LAST = CNT_W'(FILT_CYCLES - 1);

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_cnt
    logic [CNT_W-1:0] cntQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ <= '0;
      end else if (cmd[f].clr) begin
        cntQ <= '0;
      end else if (cmd[f].inc) begin
        cntQ <= cntQ + 1'b1;
      end
    end

    assign hitQual[f] = (cntQ == QUAL_LAST);
    assign hitFilt[f] = (cntQ == FILT_LAST);
  end

endmodule

// File: rtl/dws_control.sv
module dws_control
  import dws_pkg::*;
#(
  parameter int                 NUM_FLAGS = 4,
  parameter logic [NUM_FLAGS-1:0] INIT_HIGH = '0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic    [NUM_FLAGS-1:0] gate,
  input  logic    [NUM_FLAGS-1:0] condOk,
  input  logic    [NUM_FLAGS-1:0] hitQual,
  input  logic    [NUM_FLAGS-1:0] hitFilt,
  output cntCmd_t [NUM_FLAGS-1:0] cmd,
  output logic    [NUM_FLAGS-1:0] flagOut
);

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    flagState_t stateQ, stateD;
    cntCmd_t    cmdD;

    always_comb begin
      stateD   = stateQ;
      cmdD.clr = 1'b0;
      cmdD.inc = 1'b0;
      if (!gate[f]) begin
        stateD   = FL_OFF;
        cmdD.clr = 1'b1;
      end else begin
        unique case (stateQ)
          FL_OFF: begin
            stateD   = INIT_HIGH[f] ? FL_HIGH : FL_LOW;
            cmdD.clr = 1'b1;
          end
          FL_LOW: begin
            if (!condOk[f]) begin
              cmdD.clr = 1'b1;
            end else if (hitQual[f]) begin
              stateD   = FL_HIGH;
              cmdD.clr = 1'b1;
            end else begin
              cmdD.inc = 1'b1;
            end
          end
          FL_HIGH: begin
            if (condOk[f]) begin
              cmdD.clr = 1'b1;
            end else if (hitFilt[f]) begin
              stateD   = FL_LOW;
              cmdD.clr = 1'b1;
            end else begin
              cmdD.inc = 1'b1;
            end
          end
          default: begin
            stateD   = FL_OFF;
            cmdD.clr = 1'b1;
          end
        endcase
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stateQ <= FL_OFF;
      else       stateQ <= stateD;
    end

    assign cmd[f]     = cmdD;
    assign flagOut[f] = (stateQ == FL_HIGH);
  end

endmodule

// File: rtl/dual_window_supervisor.sv
module dual_window_supervisor
  import dws_pkg::*;
#(
  parameter int NUM_PAIRS   = 2,
  parameter int QUAL_CYCLES = 20_000_000,
  parameter int FILT_CYCLES = 3750
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 biasOk,
  input  logic [NUM_PAIRS-1:0] en,
  input  logic [NUM_PAIRS-1:0] uvAbove,
  input  logic [NUM_PAIRS-1:0] ovAbove,
  output logic [NUM_PAIRS-1:0] uvStatus,
  output logic [NUM_PAIRS-1:0] ovStatus,
  output logic [NUM_PAIRS-1:0] pwrGood
);

  localparam int NUM_FLAGS = 2 * NUM_PAIRS;
  // Odd flag of each pair is the high-side flag and starts asserted
  localparam logic [NUM_FLAGS-1:0] OV_MASK = {NUM_PAIRS{2'b10}};

  logic    [NUM_FLAGS-1:0] gate, condOk, hitQual, hitFilt, flagOut;
  cntCmd_t [NUM_FLAGS-1:0] cmd;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign gate[2*p]     = biasOk & en[p];
    assign gate[2*p+1]   = biasOk & en[p];
    assign condOk[2*p]   = uvAbove[p];
    assign condOk[2*p+1] = ~ovAbove[p];
    assign uvStatus[p]   = flagOut[2*p];
    assign ovStatus[p]   = flagOut[2*p+1];
    assign pwrGood[p]    = flagOut[2*p] & flagOut[2*p+1];
  end

  dws_control #(
    .NUM_FLAGS (NUM_FLAGS),
    .INIT_HIGH (OV_MASK)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .gate    (gate),
    .condOk  (condOk),
    .hitQual (hitQual),
    .hitFilt (hitFilt),
    .cmd     (cmd),
    .flagOut (flagOut)
  );

  dws_datapath #(
    .NUM_FLAGS   (NUM_FLAGS),
    .QUAL_CYCLES (QUAL_CYCLES),
    .FILT_CYCLES (FILT_CYCLES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .hitQual (hitQual),
    .hitFilt (hitFilt)
  );

endmodule

// File: rtl/dws_checker.sv
module dws_checker #(
  parameter int NUM_PAIRS = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 biasOk,
  input logic [NUM_PAIRS-1:0] en,
  input logic [NUM_PAIRS-1:0] uvAbove,
  input logic [NUM_PAIRS-1:0] ovAbove,
  input logic [NUM_PAIRS-1:0] uvStatus,
  input logic [NUM_PAIRS-1:0] ovStatus,
  input logic [NUM_PAIRS-1:0] pwrGood
);

  // R1
  bias_low_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !biasOk |=> (uvStatus == '0 && ovStatus == '0 && pwrGood == '0));

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_chk
    // R8
    pair_off_chk: assert property (@(posedge clk) disable iff (!rstN)
      !en[p] |=> (!uvStatus[p] && !ovStatus[p] && !pwrGood[p]));

    // R2
    ov_start_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ovStatus[p]) |-> $past(biasOk && en[p]));

    // R3
    uv_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(uvStatus[p]) |-> $past(uvAbove[p] && biasOk && en[p]));

    // R5
    uv_fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(uvStatus[p]) |-> $past(!uvAbove[p] || !biasOk || !en[p]));

    // R6
    ov_fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(ovStatus[p]) |-> $past(ovAbove[p] || !biasOk || !en[p]));

    // R4
    pg_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pwrGood[p]) |-> $past(biasOk && en[p] && !ovAbove[p] || uvAbove[p]));
  end

endmodule

bind dual_window_supervisor dws_checker #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .biasOk   (biasOk),
  .en       (en),
  .uvAbove  (uvAbove),
  .ovAbove  (ovAbove),
  .uvStatus (uvStatus),
  .ovStatus (ovStatus),
  .pwrGood  (pwrGood)
);

// File: tb/dual_window_supervisor_tb.sv
module dual_window_supervisor_tb;

  localparam int QUAL = 8;
  localparam int FILT = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       biasOk = 1'b0;
  logic [1:0] en = 2'b00, uvAbove = 2'b00, ovAbove = 2'b00;
  logic [1:0] uvStatus, ovStatus, pwrGood;
  int         nVec = 0;
  int         nBad = 0;

  always #4 clk = ~clk;

  dual_window_supervisor #(
    .NUM_PAIRS   (2),
    .QUAL_CYCLES (QUAL),
    .FILT_CYCLES (FILT)
  ) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .biasOk   (biasOk),
    .en       (en),
    .uvAbove  (uvAbove),
    .ovAbove  (ovAbove),
    .uvStatus (uvStatus),
    .ovStatus (ovStatus),
    .pwrGood  (pwrGood)
  );

  typedef struct packed {
    logic       bias;
    logic [1:0] en;
    logic [1:0] uv;
    logic [1:0] ov;
    logic [7:0] n;
    logic [1:0] eUv;
    logic [1:0] eOv;
    logic [1:0] ePg;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b11, 2'b11, 2'b00, 8'd1, 2'b00, 2'b11, 2'b00, 4'd2}, // R2 start
    '{1'b1, 2'b11, 2'b11, 2'b00, 8'd7, 2'b00, 2'b11, 2'b00, 4'd3}, // R3 one short
    '{1'b1, 2'b11, 2'b11, 2'b00, 8'd1, 2'b11, 2'b11, 2'b11, 4'd3}, // R3 reached
    '{1'b1, 2'b11, 2'b10, 2'b00, 8'd2, 2'b11, 2'b11, 2'b11, 4'd5}, // R5 glitch ignored
    '{1'b1, 2'b11, 2'b11, 2'b00, 8'd1, 2'b11, 2'b11, 2'b11, 4'd5},
    '{1'b1, 2'b11, 2'b10, 2'b00, 8'd3, 2'b10, 2'b11, 2'b10, 4'd5}, // R5 R9 trip pair0
    '{1'b1, 2'b11, 2'b11, 2'b00, 8'd7, 2'b10, 2'b11, 2'b10, 4'd3},
    '{1'b1, 2'b11, 2'b10, 2'b00, 8'd1, 2'b10, 2'b11, 2'b10, 4'd3}, // R3 interrupt
    '{1'b1, 2'b11, 2'b11, 2'b00, 8'd7, 2'b10, 2'b11, 2'b10, 4'd3}, // R3 restarted
    '{1'b1, 2'b11, 2'b11, 2'b00, 8'd1, 2'b11, 2'b11, 2'b11, 4'd3},
    '{1'b1, 2'b11, 2'b11, 2'b10, 8'd2, 2'b11, 2'b11, 2'b11, 4'd6}, // R6 glitch ignored
    '{1'b1, 2'b11, 2'b11, 2'b00, 8'd1, 2'b11, 2'b11, 2'b11, 4'd6},
    '{1'b1, 2'b11, 2'b11, 2'b10, 8'd3, 2'b11, 2'b01, 2'b01, 4'd6}, // R6 trip pair1
    '{1'b1, 2'b11, 2'b11, 2'b00, 8'd7, 2'b11, 2'b01, 2'b01, 4'd7}, // R7 one short
    '{1'b1, 2'b11, 2'b11, 2'b00, 8'd1, 2'b11, 2'b11, 2'b11, 4'd7}, // R7 back
    '{1'b1, 2'b10, 2'b11, 2'b00, 8'd1, 2'b10, 2'b10, 2'b10, 4'd8}, // R8 R9 pair0 off
    '{1'b1, 2'b11, 2'b11, 2'b00, 8'd1, 2'b10, 2'b11, 2'b10, 4'd8}, // R8 restart
    '{1'b1, 2'b11, 2'b11, 2'b00, 8'd8, 2'b11, 2'b11, 2'b11, 4'd8}, // R8 requalified
    '{1'b0, 2'b11, 2'b11, 2'b00, 8'd1, 2'b00, 2'b00, 2'b00, 4'd1}, // R1 bias low
    '{1'b1, 2'b11, 2'b11, 2'b11, 8'd1, 2'b00, 2'b11, 2'b00, 4'd2}, // R2 ov high at start
    '{1'b1, 2'b11, 2'b11, 2'b11, 8'd3, 2'b00, 2'b00, 2'b00, 4'd6},
    '{1'b1, 2'b11, 2'b11, 2'b00, 8'd5, 2'b11, 2'b00, 2'b00, 4'd4}, // R4 uv alone
    '{1'b1, 2'b11, 2'b11, 2'b00, 8'd3, 2'b11, 2'b11, 2'b11, 4'd7}  // R7 R4 both
  };

  task automatic check(input logic [1:0] eUv, input logic [1:0] eOv,
                       input logic [1:0] ePg, input int req);
    nVec++;
    if ({uvStatus, ovStatus, pwrGood} !== {eUv, eOv, ePg}) begin
      nBad++;
      $display("FAIL R%0d vec %0d: uv/ov/pg actual=%b/%b/%b expected=%b/%b/%b",
               req, nVec, uvStatus, ovStatus, pwrGood, eUv, eOv, ePg);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(2'b00, 2'b00, 2'b00, 1); // R1 reset state
    rstN = 1'b1;
    @(negedge clk);
    check(2'b00, 2'b00, 2'b00, 1); // R1 bias still low
    for (int i = 0; i < NV; i++) begin
      biasOk  = VECS[i].bias;
      en      = VECS[i].en;
      uvAbove = VECS[i].uv;
      ovAbove = VECS[i].ov;
      repeat (int'(VECS[i].n)) @(posedge clk);
      @(negedge clk);
      check(VECS[i].eUv, VECS[i].eOv, VECS[i].ePg, int'(VECS[i].req));
    end
    // R1 asynchronous reset while everything is good
    rstN = 1'b0;
    #1;
    check(2'b00, 2'b00, 2'b00, 1);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(2'b00, 2'b11, 2'b00, 2); // R2 restart after reset
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule